// File: doc/BRIEF.md
# Load-Multiple Line-Boundary Splitter

This block takes one noncacheable multi-word load, given as a word-aligned byte address and a word count, and turns it into an ordered series of read operations. No operation reaches past the end of a 32-byte line of eight words. The first operation begins at the requested word and stops at the line end or when the count runs out. Each later operation begins at offset zero of the next line. Any operation other than the final one covers a whole line.

The operations leave the block one at a time on a valid/ready output. Each carries three things: the line base address, the byte offset inside that line, and the number of words. A flag marks an operation that moves a single word, so it can go out as a plain single load. A second flag marks the final operation of the request.

A request is accepted only while the block is idle. Busy stays high until the consumer takes the final operation. A request whose count is outside 1 to 16 is consumed, but it produces no operation.

Top module: `lds_splitter`

## Requirements
- R1: After synchronous reset, op_valid and busy are 0 and req_ready is 1.
- R2: req_ready equals the inverse of busy. A request is taken only on a cycle with req_valid and req_ready both high. From the cycle after a valid request is taken, busy stays high until the cycle after its last operation is taken.
- R3: The first operation has the following fields. op_line is req_addr with its low 5 bits cleared. op_offset is 4 times the start word w, where w is req_addr[4:2]. op_words is the smaller of 8-w and the count.
- R4: Every operation after the first has op_offset 0. Its op_line is the previous op_line plus 32.
- R5: Every operation that is neither first nor last has exactly 8 words. Leftover words form a final operation at offset 0. For example, 16 words from word 0 give 8+8, and 16 words from word 1 give 7+8+1.
- R6: op_single is 1 exactly when op_words is 1. For example, 9 words from word 7 give a single load at offset 0x1C, then 8 words at offset 0.
- R7: op_last is 1 only on the final operation. op_valid drops in the cycle after that operation is taken. The op_words of one request sum to its count.
- R8: While op_valid is high and op_ready is low, all op_* outputs hold their values.
- R9: A request taken with count 0 or above 16 produces no operation, and busy stays 0.
- R10: No operation crosses a line: op_offset/4 + op_words is at most 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Word-aligned start byte address |
| req_count | input | 5 | Number of words, 1 to 16 |
| op_valid | output | 1 | Operation present |
| op_ready | input | 1 | Consumer takes the operation |
| op_line | output | 32 | Line base address of the operation |
| op_offset | output | 5 | Byte offset within the line |
| op_words | output | 5 | Words moved by the operation |
| op_single | output | 1 | Operation is a single-word load |
| op_last | output | 1 | Final operation of the request |
| busy | output | 1 | A request is being split |

## Verification
Two events can fall in the same cycle: the hand-off of the final operation and a waiting request. The driver holds req_valid high through a whole split. The check is that the request is taken only on the cycle after the final operation leaves, with op_valid low at that moment. The single-word flag and the last flag also coincide on remainder chunks, as in 7+8+1. Every start word from 0 to 7 is swept against every count from 1 to 16, under three consumer stall patterns. A scoreboard compares each operation in order and checks the sum of the chunks and the line limit.

// File: rtl/lds_pkg.sv
package lds_pkg;
    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int WORD_BYTES = 4;
    localparam int MAX_WORDS  = 16;

    localparam int LINE_WORDS = LINE_BYTES / WORD_BYTES;
    localparam int WIDX_W     = $clog2(LINE_WORDS);
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int BSEL_W     = $clog2(WORD_BYTES);
    localparam int CNT_W      = $clog2(MAX_WORDS + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [WIDX_W-1:0] widx_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [OFF_W-1:0]  off_t;

    // Position of the walk through a request
    typedef struct packed {
        addr_t line;
        widx_t widx;
        cnt_t  rem;
    } walk_t;

    // One outgoing read operation
    typedef struct packed {
        addr_t line;
        off_t  offset;
        cnt_t  words;
        logic  single;
        logic  last;
    } op_t;

    function automatic cnt_t room_in_line(widx_t w);
        return cnt_t'(LINE_WORDS) - cnt_t'(w);
    endfunction

    function automatic logic count_ok(cnt_t c);
        return (c != '0) && (c <= cnt_t'(MAX_WORDS));
    endfunction
endpackage

// File: rtl/lds_chunk.sv
module lds_chunk
    import lds_pkg::*;
(
    input  logic  active,
    input  walk_t cur,
    output op_t   op
);
    cnt_t room;
    cnt_t n;

    always_comb begin
        room      = room_in_line(cur.widx);
        n         = (room < cur.rem) ? room : cur.rem;
        op.line   = cur.line;
        op.offset = {cur.widx, {BSEL_W{1'b0}}};
        op.words  = n;
        op.single = (n == cnt_t'(1));
        op.last   = (n == cur.rem);
    end

    // R10
    always_comb begin
        if (active) begin
            no_line_cross_chk: assert ((int'(op.offset) / WORD_BYTES) + int'(op.words) <= LINE_WORDS);
        end
    end
endmodule

// File: rtl/lds_walker.sv
module lds_walker
    import lds_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  walk_t start_pos,
    input  logic  step,
    input  logic  step_last,
    input  cnt_t  step_words,
    output walk_t cur,
    output logic  busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cur  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cur  <= start_pos;
            end
        end else if (step) begin
            if (step_last) begin
                busy <= 1'b0;
            end else begin
                cur.line <= cur.line + addr_t'(LINE_BYTES);
                cur.widx <= '0;
                cur.rem  <= cur.rem - step_words;
            end
        end
    end

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !(step && step_last) |=> busy);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !busy && start |=> busy);
endmodule

// File: rtl/lds_splitter.sv
module lds_splitter
    import lds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_count,
    output logic              op_valid,
    input  logic              op_ready,
    output logic [ADDR_W-1:0] op_line,
    output logic [OFF_W-1:0]  op_offset,
    output logic [CNT_W-1:0]  op_words,
    output logic              op_single,
    output logic              op_last,
    output logic              busy
);
    walk_t start_pos;
    walk_t cur;
    op_t   op;
    logic  start;
    logic  step;

    assign start_pos.line = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign start_pos.widx = req_addr[OFF_W-1:BSEL_W];
    assign start_pos.rem  = req_count;

    assign req_ready = !busy;
    assign start     = req_valid && count_ok(req_count);
    assign op_valid  = busy;
    assign step      = op_valid && op_ready;

    lds_walker u_walker (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_pos  (start_pos),
        .step       (step),
        .step_last  (op.last),
        .step_words (op.words),
        .cur        (cur),
        .busy       (busy)
    );

    lds_chunk u_chunk (
        .active (busy),
        .cur    (cur),
        .op     (op)
    );

    assign op_line   = op.line;
    assign op_offset = op.offset;
    assign op_words  = op.words;
    assign op_single = op.single;
    assign op_last   = op.last;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !op_ready |=> op_valid && $stable(op_line) && $stable(op_offset) && $stable(op_words));

    // R4
    next_line_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_ready && !op_last |=> op_valid && (op_offset == '0) && (op_line == $past(op_line) + addr_t'(LINE_BYTES)));

    // R5
    middle_full_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && !op_last && (op_offset == '0) |-> (op_words == cnt_t'(LINE_WORDS)));

    // R7
    last_drop_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid && op_ready && op_last |=> !op_valid);

    // R9
    bad_count_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !count_ok(req_count) |=> !busy);
endmodule

// File: tb/tb_lds_splitter.sv
`timescale 1ns/1ps
module tb_lds_splitter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_count = '0;
    logic        op_valid;
    logic        op_ready = 1'b1;
    logic [31:0] op_line;
    logic [4:0]  op_offset;
    logic [4:0]  op_words;
    logic        op_single;
    logic        op_last;
    logic        busy;

    always #2 clk = ~clk;

    lds_splitter dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_count(req_count), .op_valid(op_valid),
        .op_ready(op_ready), .op_line(op_line), .op_offset(op_offset),
        .op_words(op_words), .op_single(op_single), .op_last(op_last), .busy(busy)
    );

    typedef struct {
        logic [31:0] line;
        int          off;
        int          words;
        bit          single;
        bit          last;
        bit          first;
        int          total;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    int   stall_mode = 0;
    int   cyc = 0;
    bit   done = 0;

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // consumer pacing
    always @(posedge clk) begin
        #1;
        cyc++;
        case (stall_mode)
            0: op_ready = 1'b1;
            1: op_ready = (cyc % 3) != 0;
            default: op_ready = (cyc % 5) == 0;
        endcase
    end

    // scoreboard monitor
    bit          hold_pend = 0;
    logic [31:0] h_line;
    logic [4:0]  h_off, h_words;
    int          sum = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (hold_pend) begin
                chk(op_valid && op_line == h_line && op_offset == h_off && op_words == h_words,
                    "R8", "held op changed", {op_line, op_offset}, {h_line, h_off});
            end
            if (op_valid && op_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected op", op_words, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(op_line == e.line, e.first ? "R3" : "R4", "line", op_line, e.line);
                    chk(int'(op_offset) == e.off, e.first ? "R3" : "R4", "offset", op_offset, e.off);
                    chk(int'(op_words) == e.words, e.first ? "R3" : "R5", "words", op_words, e.words);
                    chk(op_single == e.single, "R6", "single", op_single, e.single);
                    chk(op_last == e.last, "R7", "last", op_last, e.last);
                    chk(int'(op_offset) / 4 + int'(op_words) <= 8, "R10", "line crossing",
                        int'(op_offset) / 4 + int'(op_words), 8);
                    sum += int'(op_words);
                    if (op_last) begin
                        chk(sum == e.total, "R7", "chunk sum", sum, e.total);
                        sum = 0;
                    end
                end
            end
            hold_pend = op_valid && !op_ready;
            h_line = op_line;
            h_off = op_offset;
            h_words = op_words;
        end
    end

    // driver: computes expected ops from the requirements and issues the request
    task automatic send(logic [31:0] a, int c);
        if (c >= 1 && c <= 16) begin
            int w = int'(a[4:2]);
            int rem = c;
            logic [31:0] ln = {a[31:5], 5'b0};
            bit first = 1;
            while (rem > 0) begin
                exp_t e;
                int n = 8 - w;
                if (n > rem) n = rem;
                e.line = ln; e.off = w * 4; e.words = n; e.single = (n == 1);
                e.last = (n == rem); e.first = first; e.total = c;
                exp_q.push_back(e);
                rem -= n; w = 0; ln += 32; first = 0;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = a; req_count = 5'(c);
        while (1) begin
            @(negedge clk);
            if (req_ready) break;
        end
        // R2: taken only once idle, with no operation pending
        chk(!op_valid && !busy, "R2", "accept while active", {op_valid, busy}, 0);
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (!(c >= 1 && c <= 16)) begin
            @(negedge clk);
            chk(!busy && !op_valid, "R9", "bad count started work", {busy, op_valid}, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!op_valid && !busy && req_ready, "R1", "reset state", {op_valid, busy, req_ready}, 1);
        @(posedge clk); #1;
        rst = 1'b0;

        stall_mode = 0;
        send(32'h0000_1000, 16);
        send(32'h0000_1004, 16);
        send(32'h0000_101C, 9);
        send(32'h0000_1018, 1);
        stall_mode = 2;
        send(32'h0000_2000, 0);
        send(32'h0000_2000, 17);
        send(32'h0000_2000, 31);
        send(32'h0000_2014, 12);
        for (int w = 0; w < 8; w++) begin
            for (int c = 1; c <= 16; c++) begin
                stall_mode = (w + c) % 3;
                send(32'h2000_0000 + 32'((w * 16 + c) * 64) + 32'(w * 4), c);
            end
        end
        while (exp_q.size() != 0 || busy) @(negedge clk);
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule